// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for each frame arriving at a 10G Ethernet receiver, whether the frame is kept or dropped, based only on its 48-bit destination address. The receive front end presents the address with a one-cycle valid strobe. Two cycles later the block returns a registered keep/drop decision with its own strobe. One address can be presented every cycle.

Three mechanisms can accept a frame:
- A set of exact-match entries. Each entry can be enabled on its own, and entry 0 holds the broadcast address from reset.
- A 64-bit multicast hash table. It is indexed by six bits of the Ethernet CRC-32 of the address.
- A promiscuous override that accepts every frame.

Software programs the filter through a write-only port of 16-bit registers: four hash words, a mode word, an entry-enable word and three address words per entry. The intended sequence is to clear an entry's enable bit, rewrite its address words, and then set the enable bit again.

Top module: `rx_da_filter`

## Requirements
- R1: After reset, accept_vld_o and accept_o are 0. Exact entry 0 holds all-ones and is enabled; the other entries are disabled and zero. All hash words are zero, and promiscuous and hash mode are off.
- R2: For each cycle with da_vld_i high, accept_vld_o is high exactly two clock edges later, once per address, so back-to-back addresses give back-to-back results. accept_o is 0 whenever accept_vld_o is 0.
- R3: Address byte k of the destination is da_i[8k+7:8k], with byte 0 first on the wire. Entry e has three address words at config addresses 8+4e (low), 8+4e+1 (mid) and 8+4e+2 (high). The low word holds byte 1 in bits 15:8 and byte 0 in bits 7:0, and the mid and high words hold bytes 3:2 and 5:4 in the same pattern. Bit e of the enable word (address 5) enables entry e. An enabled entry whose 48 bits all equal da_i causes an accept.
- R4: A disabled entry never causes an accept. An enabled entry whose address differs from da_i in even one bit does not cause an accept.
- R5: With mode bit 1 (hash enable, mode word at address 4) set, a multicast address (da_i[0] = 1) is accepted when its indexed hash bit is 1. The index is bits 28:23 of the Ethernet CRC-32 over the six address bytes: the register is preset to all-ones, each byte is fed least significant bit first, the polynomial is 0x04C11DB7 shifted MSB-first, and there is no final inversion. Index bits 5:4 select hash word 0..3 at config addresses 0..3, and index bits 3:0 select the bit within that word.
- R6: An address with da_i[0] = 0 is never accepted through the hash table, even when every hash bit is 1.
- R7: With hash enable clear, the hash table has no effect on the decision.
- R8: Mode bit 0 (promiscuous) set causes every address to be accepted, whatever the other filters decide.
- R9: A configuration write in the same cycle as an address valid is not seen by that lookup. It is seen by every lookup presented in a later cycle.
- R10: Right after reset, the broadcast address (all-ones) is accepted and other addresses are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | CFG_AW | Configuration register address |
| cfg_wdata_i | input | 16 | Configuration write data |
| da_vld_i | input | 1 | Destination address valid |
| da_i | input | 48 | Destination address, byte 0 in bits 7:0 |
| accept_vld_o | output | 1 | Decision valid, two cycles after da_vld_i |
| accept_o | output | 1 | 1 = keep frame, 0 = drop |

## Verification
The two functions that can coincide are a configuration write and an address lookup arriving on the same clock edge. The race shows up in the promiscuous bit and in the entry-enable word. The bench provokes it by driving a write and an address valid in the same cycle. It predicts that this lookup still uses the old setting and that the lookup in the next cycle uses the new one. Back-to-back addresses and a scoreboard timestamp on every expected result also confirm that the decision lands on the second edge, with no slip when lookups are dense.

// File: rtl/rx_da_filter_pkg.sv
package rx_da_filter_pkg;
  localparam int unsigned DA_W        = 48;
  localparam int unsigned DA_BYTES    = DA_W / 8;
  localparam int unsigned CFG_DW      = 16;
  localparam int unsigned HASH_BITS   = 64;
  localparam int unsigned HASH_IDX_W  = $clog2(HASH_BITS);
  localparam int unsigned HASH_WORDS  = HASH_BITS / CFG_DW;
  localparam int unsigned HASH_LSB    = 23;
  localparam int unsigned WORDS_PER_DA = DA_W / CFG_DW;
  // register map
  localparam int unsigned HASH_BASE   = 0;
  localparam int unsigned MODE_ADDR   = 4;
  localparam int unsigned EN_ADDR     = 5;
  localparam int unsigned EX_BASE     = 8;
  localparam int unsigned EX_STRIDE   = 4;
  localparam int unsigned MODE_PROMISC_BIT = 0;
  localparam int unsigned MODE_HASH_BIT    = 1;
  localparam logic [31:0] CRC_POLY    = 32'h04C1_1DB7;

  // CRC-32, MSB-first register, data bits LSB-first per byte, no final inversion
  function automatic logic [HASH_IDX_W-1:0] da_hash_idx(input logic [DA_W-1:0] da);
    logic [31:0] c;
    logic        fb;
    c = '1;
    for (int b = 0; b < int'(DA_BYTES); b++) begin
      for (int i = 0; i < 8; i++) begin
        fb = c[31] ^ da[8*b+i];
        c  = {c[30:0], 1'b0};
        if (fb) c = c ^ CRC_POLY;
      end
    end
    return c[HASH_LSB +: HASH_IDX_W];
  endfunction
endpackage

// File: rtl/rx_da_cfg_regs.sv
module rx_da_cfg_regs
  import rx_da_filter_pkg::*;
#(
  parameter int unsigned NUM_EXACT = 4,
  parameter int unsigned CFG_AW    = 6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [CFG_AW-1:0]             addr_i,
  input  logic [CFG_DW-1:0]             wdata_i,
  output logic [HASH_BITS-1:0]          hash_o,
  output logic                          promisc_o,
  output logic                          hash_en_o,
  output logic [NUM_EXACT-1:0]          ex_en_o,
  output logic [NUM_EXACT-1:0][DA_W-1:0] ex_addr_o
);
  logic [HASH_WORDS-1:0][CFG_DW-1:0] hash_q;
  logic                              promisc_q, hash_en_q;
  logic [NUM_EXACT-1:0]              en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hash_q <= '0;
    end else if (we_i) begin
      for (int w = 0; w < int'(HASH_WORDS); w++)
        if (addr_i == CFG_AW'(HASH_BASE + w)) hash_q[w] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      promisc_q <= 1'b0;
      hash_en_q <= 1'b0;
    end else if (we_i && addr_i == CFG_AW'(MODE_ADDR)) begin
      promisc_q <= wdata_i[MODE_PROMISC_BIT];
      hash_en_q <= wdata_i[MODE_HASH_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               en_q <= NUM_EXACT'(1);
    else if (we_i && addr_i == CFG_AW'(EN_ADDR)) en_q <= wdata_i[NUM_EXACT-1:0];
  end

  for (genvar e = 0; e < int'(NUM_EXACT); e++) begin : g_ent
    localparam logic [DA_W-1:0] RST_VAL = (e == 0) ? '1 : '0;
    logic [DA_W-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q <= RST_VAL;
      end else if (we_i) begin
        for (int w = 0; w < int'(WORDS_PER_DA); w++)
          if (addr_i == CFG_AW'(EX_BASE + EX_STRIDE*e + w)) ent_q[CFG_DW*w +: CFG_DW] <= wdata_i;
      end
    end
    assign ex_addr_o[e] = ent_q;
  end

  assign hash_o    = hash_q;
  assign promisc_o = promisc_q;
  assign hash_en_o = hash_en_q;
  assign ex_en_o   = en_q;

  // R9
  hash_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(hash_q));
  // R9
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(en_q));
endmodule

// File: rtl/rx_da_crc_hash.sv
module rx_da_crc_hash
  import rx_da_filter_pkg::*;
(
  input  logic [DA_W-1:0]       da_i,
  output logic [HASH_IDX_W-1:0] idx_o
);
  assign idx_o = da_hash_idx(da_i);
endmodule

// File: rtl/rx_da_exact_cmp.sv
module rx_da_exact_cmp
  import rx_da_filter_pkg::*;
#(
  parameter int unsigned NUM_EXACT = 4
) (
  input  logic [DA_W-1:0]                da_i,
  input  logic [NUM_EXACT-1:0]           en_i,
  input  logic [NUM_EXACT-1:0][DA_W-1:0] tab_i,
  output logic [NUM_EXACT-1:0]           hit_o
);
  for (genvar e = 0; e < int'(NUM_EXACT); e++) begin : g_cmp
    assign hit_o[e] = en_i[e] && (tab_i[e] == da_i);
  end
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
  import rx_da_filter_pkg::*;
#(
  parameter int unsigned NUM_EXACT = 4,
  parameter int unsigned CFG_AW    = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [15:0]       cfg_wdata_i,
  input  logic              da_vld_i,
  input  logic [47:0]       da_i,
  output logic              accept_vld_o,
  output logic              accept_o
);
  logic [HASH_BITS-1:0]           hash_tab;
  logic                           promisc, hash_en;
  logic [NUM_EXACT-1:0]           ex_en, ex_hit;
  logic [NUM_EXACT-1:0][DA_W-1:0] ex_tab;
  logic [HASH_IDX_W-1:0]          hash_idx;
  logic                           hash_hit;

  rx_da_cfg_regs #(.NUM_EXACT(NUM_EXACT), .CFG_AW(CFG_AW)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .hash_o(hash_tab), .promisc_o(promisc), .hash_en_o(hash_en),
    .ex_en_o(ex_en), .ex_addr_o(ex_tab)
  );

  rx_da_crc_hash u_hash (.da_i(da_i), .idx_o(hash_idx));

  rx_da_exact_cmp #(.NUM_EXACT(NUM_EXACT)) u_cmp (
    .da_i(da_i), .en_i(ex_en), .tab_i(ex_tab), .hit_o(ex_hit)
  );

  // multicast = first transmitted bit of byte 0
  assign hash_hit = da_i[0] && hash_en && hash_tab[hash_idx];

  // stage 1: every config-dependent term sampled on the same edge
  logic s1_vld, s1_promisc, s1_exact, s1_hash;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld     <= 1'b0;
      s1_promisc <= 1'b0;
      s1_exact   <= 1'b0;
      s1_hash    <= 1'b0;
    end else begin
      s1_vld     <= da_vld_i;
      s1_promisc <= da_vld_i && promisc;
      s1_exact   <= da_vld_i && (|ex_hit);
      s1_hash    <= da_vld_i && hash_hit;
    end
  end

  // stage 2: decision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_vld_o <= 1'b0;
      accept_o     <= 1'b0;
    end else begin
      accept_vld_o <= s1_vld;
      accept_o     <= s1_vld && (s1_promisc || s1_exact || s1_hash);
    end
  end

  // R2
  lat_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    da_vld_i |=> ##1 accept_vld_o);
  // R2
  no_spur_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_vld_o |-> $past(da_vld_i, 2));
  // R2
  acc_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_vld_o |-> !accept_o);
  // R8
  promisc_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_vld && s1_promisc |=> accept_o);
  // R3
  exact_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_vld && s1_exact |=> accept_o);
  // R4
  drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_vld && !s1_promisc && !s1_exact && !s1_hash |=> !accept_o);
endmodule

// File: tb/rx_da_filter_tb_top.sv
`timescale 1ns/1ps
module rx_da_filter_tb_top;
  localparam int NE = 4;
  localparam int AW = 6;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [AW-1:0] cfg_addr_i = '0;
  logic [15:0]   cfg_wdata_i = '0;
  logic          da_vld_i = 1'b0;
  logic [47:0]   da_i = '0;
  logic          accept_vld_o, accept_o;

  always #2 clk_i = ~clk_i;

  rx_da_filter #(.NUM_EXACT(NE), .CFG_AW(AW)) dut_i (.*);

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  // shadow configuration, per the register map in the requirements
  logic [15:0]   hash_m [4];
  logic [1:0]    mode_m;
  logic [NE-1:0] en_m;
  logic [47:0]   ex_m [NE];

  // scoreboard
  bit    exp_q [$];
  int    cyc_q [$];
  string tag_q [$];
  logic [47:0] da_q [$];

  function automatic logic [5:0] tb_idx(input logic [47:0] da);
    logic [31:0] r;
    r = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      if (r[31] != da[k]) r = (r << 1) ^ 32'h04C1_1DB7;
      else                r = r << 1;
    end
    return r[28:23];
  endfunction

  function automatic bit model(input logic [47:0] da);
    logic [5:0] ix;
    bit hit;
    ix  = tb_idx(da);
    hit = 1'b0;
    for (int e = 0; e < NE; e++) if (en_m[e] && ex_m[e] == da) hit = 1'b1;
    return mode_m[0] | hit | (da[0] & mode_m[1] & hash_m[ix[5:4]][ix[3:0]]);
  endfunction

  function automatic void shadow_wr(input int a, input logic [15:0] d);
    if (a < 4) hash_m[a] = d;
    else if (a == 4) mode_m = d[1:0];
    else if (a == 5) en_m = d[NE-1:0];
    else if (a >= 8 && a < 8 + 4*NE && ((a - 8) % 4) < 3)
      ex_m[(a-8)/4][16*((a-8)%4) +: 16] = d;
  endfunction

  task automatic push(input logic [47:0] da, input bit exp, input string tag);
    exp_q.push_back(exp); cyc_q.push_back(cyc); tag_q.push_back(tag); da_q.push_back(da);
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = AW'(a); cfg_wdata_i = d; da_vld_i = 1'b0;
    shadow_wr(a, d);
  endtask

  task automatic send(input logic [47:0] da, input string tag);
    @(negedge clk_i);
    cfg_we_i = 1'b0; da_vld_i = 1'b1; da_i = da;
    push(da, model(da), tag);
  endtask

  task automatic both(input int a, input logic [15:0] d, input logic [47:0] da, input string tag);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = AW'(a); cfg_wdata_i = d;
    da_vld_i = 1'b1; da_i = da;
    push(da, model(da), tag);   // old configuration
    shadow_wr(a, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      cfg_we_i = 1'b0; da_vld_i = 1'b0;
    end
  endtask

  task automatic prog_entry(input int e, input logic [47:0] da);
    logic [NE-1:0] en_n;
    en_n = en_m & ~(NE'(1) << e);
    wr(5, 16'(en_n));
    for (int w = 0; w < 3; w++) wr(8 + 4*e + w, da[16*w +: 16]);
    wr(5, 16'(en_n | (NE'(1) << e)));
  endtask

  task automatic check_val(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] mc_in_word(input int w, input int nth);
    int seen;
    logic [47:0] a;
    seen = 0;
    for (int k = 0; k < 1024; k++) begin
      a = {16'(k), 8'h00, 8'h5E, 8'h00, 8'h01};
      if (int'(tb_idx(a) >> 4) == w) begin
        if (seen == nth) return a;
        seen++;
      end
    end
    return 48'h0000_0000_0001;
  endfunction

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (accept_vld_o) begin
        if (exp_q.size() == 0) begin
          checks++; failures++;
          $display("FAIL R2 unexpected result actual=1 expected=0");
        end else begin
          bit e; int c; string t; logic [47:0] d;
          e = exp_q.pop_front(); c = cyc_q.pop_front();
          t = tag_q.pop_front(); d = da_q.pop_front();
          checks++;
          if (accept_o !== e || (cyc - c) != 2) begin
            failures++;
            $display("FAIL %s da=%h accept=%0b expected=%0b latency=%0d expected_latency=2",
                     t, d, accept_o, e, cyc - c);
          end
        end
      end else if (accept_o) begin
        checks++; failures++;
        $display("FAIL R2 accept without valid actual=1 expected=0");
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [47:0] sta_a, sta_b, mc1, mc2, uni;
    logic [5:0]  ix;
    for (int w = 0; w < 4; w++) hash_m[w] = '0;
    mode_m = '0; en_m = NE'(1);
    for (int e = 0; e < NE; e++) ex_m[e] = (e == 0) ? '1 : '0;
    sta_a = 48'h0913_0043_0702;
    sta_b = 48'h5544_3322_1102;
    uni   = 48'hABCD_EF01_2346;

    repeat (3) @(negedge clk_i);
    check_val(accept_vld_o, 1'b0, "R1 reset valid");
    check_val(accept_o, 1'b0, "R1 reset accept");
    rst_ni = 1'b1;
    idle(2);

    // R10 / R1: only broadcast passes after reset
    send(48'hFFFF_FFFF_FFFF, "R10 broadcast");
    send(sta_a, "R1 unicast dropped");
    send(mc_in_word(0, 0), "R1 multicast dropped");
    idle(3);

    // R3 exact match, entries 1 and 3
    prog_entry(1, sta_a);
    prog_entry(3, sta_b);
    send(sta_a, "R3 entry1");
    send(sta_b, "R3 entry3");
    // R4 one-bit miss and disabled entry
    send(sta_a ^ 48'h8000_0000_0000, "R4 msb differs");
    send(sta_b ^ 48'h0000_0000_0100, "R4 byte1 differs");
    idle(3);
    wr(5, 16'h0009);
    send(sta_a, "R4 entry1 disabled");
    wr(5, 16'h0008);
    send(48'hFFFF_FFFF_FFFF, "R4 broadcast entry disabled");
    idle(3);

    // R5 hash lookup, one bit per word
    wr(4, 16'h0002);
    for (int w = 0; w < 4; w++) begin
      mc1 = mc_in_word(w, 0);
      mc2 = mc_in_word(w, 1);
      ix  = tb_idx(mc1);
      for (int k = 0; k < 4; k++) wr(k, 16'h0000);
      wr(w, 16'(1) << ix[3:0]);
      send(mc1, "R5 hash bit set");
      send(mc2, "R5 hash other index");
      idle(3);
    end
    // R6 unicast never through hash
    for (int k = 0; k < 4; k++) wr(k, 16'hFFFF);
    send(uni, "R6 unicast all-ones table");
    send(mc_in_word(2, 3), "R5 all-ones accepts multicast");
    idle(3);
    // R7 hash disabled
    wr(4, 16'h0000);
    send(mc_in_word(1, 2), "R7 hash disabled");
    send(mc_in_word(3, 2), "R7 hash disabled");
    idle(3);
    // R8 promiscuous
    wr(4, 16'h0001);
    send(uni, "R8 unicast");
    send(48'h0102_0304_0507, "R8 multicast");
    send(48'h0000_0000_0000, "R8 zero address");
    idle(3);
    // R9 same-cycle write and lookup
    both(4, 16'h0000, uni, "R9 old promisc used");
    send(uni, "R9 new mode used");
    both(5, 16'h0002, sta_a, "R9 old enable used");
    send(sta_a, "R9 new enable used");
    idle(3);
    // R2 dense back-to-back mix
    for (int i = 0; i < 12; i++)
      send((i % 3 == 0) ? sta_a : ((i % 3 == 1) ? uni : mc_in_word(i % 4, i)), "R2 back-to-back");
    idle(5);

    check_val(exp_q.size() == 0, 1'b1, "R2 all results returned");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule